// File: doc/BRIEF.md
# Gamepad Poll Register Slot

This block occupies one device slot on a 16-bit memory bus and lets a processor run a two-player controller poll using only ordinary loads and stores. A store of any value to the control word asks the serial controller engine for a fresh poll. A load from the same word shows whether that poll is still running. Two more words return the button states of the two players as they stood when the most recent poll finished.

Toward the engine the block gives a one-cycle request pulse. It then waits for a one-cycle done pulse, and in that cycle it takes both 16-bit button words. The block registers its state only. Read data is formed combinationally from the bus inputs and that state. It is forced to zero whenever the slot is not taking part in a read, so several slots can be ORed onto one shared read bus.

Top module: `gpad_poll_regs`

## Requirements
- R1: After reset the busy flag is 0, both player words are 0 and `poll_req` is 0.
- R2: A store (`slot_en`=1, `rd_nwr`=0, `lane_en`≠0) to word offset 0 (byte offset 0) while idle starts a poll. The data value does not matter. In the next cycle the busy flag reads 1 and `poll_req` is high for exactly that one cycle.
- R3: No poll starts from a store with `slot_en`=0, from a store to any word offset other than 0, or from a bus cycle with both lanes inactive.
- R4: Once set, the busy flag stays 1 until a cycle in which `poll_done` is 1. It reads 0 from the following cycle on.
- R5: When `poll_done` is 1 while busy, `p1_btn_in` and `p2_btn_in` are captured in that cycle. At all other times, including a `poll_done` while idle, both player words keep their values.
- R6: A start store made while busy is ignored, and it raises no `poll_req`. This also holds in the cycle where `poll_done` arrives, so the block ends that cycle idle.
- R7: A load of word offset 0 returns the busy flag in bit 0. Bits 15:1 are 0.
- R8: A load of word offset 1 (byte offset 2) returns the player 1 word, and a load of word offset 2 (byte offset 4) returns the player 2 word. Every other word offset in the slot reads 0.
- R9: `rdata` is 0 whenever `slot_en`=0, `rd_nwr`=0 or `lane_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| slot_en | input | 1 | Slot selected by the bus address decoder |
| rd_nwr | input | 1 | 1 = read cycle, 0 = write cycle |
| lane_en | input | 2 | Active byte lanes (bit 1 upper, bit 0 lower); 0 means no access |
| word_ofs | input | ADDR_W (16) | Word offset inside the slot (byte offset / 2) |
| rdata | output | 16 | Read data, zero when not read |
| poll_req | output | 1 | One-cycle poll request to the engine |
| poll_done | input | 1 | One-cycle completion from the engine |
| p1_btn_in | input | 16 | Player 1 buttons from the engine |
| p2_btn_in | input | 16 | Player 2 buttons from the engine |

## Verification
A start store and the engine's done pulse can land in the same cycle. The block must then finish the running poll, capture the button words and drop the store, so it ends idle with no new request. The bench forces this case directly, and random traffic also produces it, because the done pulse is driven on its own while stores to offset 0 keep arriving. A cycle-level model in the bench gives the expected busy flag, request pulse and player words. Each of these is then judged through status and player reads on the following cycles.

// File: rtl/gpad_pkg.sv
package gpad_pkg;
    localparam int DATA_W   = 16;
    localparam int LANES    = DATA_W / 8;
    localparam int NPLAYERS = 2;

    localparam int OFS_STAT = 0;
    localparam int OFS_P1   = 1;
    localparam int OFS_P2   = 2;

    typedef enum logic [1:0] {
        ACC_NONE = 2'd0,
        ACC_RD   = 2'd1,
        ACC_WR   = 2'd2
    } acc_e;

    typedef enum logic [1:0] {
        TGT_NONE = 2'd0,
        TGT_STAT = 2'd1,
        TGT_P1   = 2'd2,
        TGT_P2   = 2'd3
    } tgt_e;

    typedef logic [DATA_W-1:0] word_t;
endpackage

// File: rtl/gpad_decode.sv
module gpad_decode
    import gpad_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              slot_en,
    input  logic              rd_nwr,
    input  logic [LANES-1:0]  lane_en,
    input  logic [ADDR_W-1:0] word_ofs,
    output acc_e              acc,
    output tgt_e              tgt
);
    logic any_lane;

    assign any_lane = |lane_en;

    always_comb begin
        acc = ACC_NONE;
        if (slot_en && any_lane) begin
            acc = rd_nwr ? ACC_RD : ACC_WR;
        end
    end

    always_comb begin
        tgt = TGT_NONE;
        if (word_ofs == ADDR_W'(OFS_STAT)) tgt = TGT_STAT;
        else if (word_ofs == ADDR_W'(OFS_P1)) tgt = TGT_P1;
        else if (word_ofs == ADDR_W'(OFS_P2)) tgt = TGT_P2;
    end
endmodule

// File: rtl/gpad_ctrl.sv
module gpad_ctrl
    import gpad_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_wr,
    input  logic                  poll_done,
    input  word_t [NPLAYERS-1:0]  btn_in,
    output logic                  busy,
    output logic                  poll_req,
    output word_t [NPLAYERS-1:0]  btn_q
);
    typedef struct packed {
        logic                 busy;
        logic                 req;
        word_t [NPLAYERS-1:0] btn;
    } state_t;

    state_t st_d, st_q;
    logic   finish;
    logic   launch;

    always_comb begin
        st_d   = st_q;
        launch = start_wr && !st_q.busy;
        finish = poll_done && st_q.busy;
        st_d.req = launch;
        if (launch) begin
            st_d.busy = 1'b1;
        end else if (finish) begin
            st_d.busy = 1'b0;
        end
        for (int p = 0; p < NPLAYERS; p++) begin
            if (finish) st_d.btn[p] = btn_in[p];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy     = st_q.busy;
    assign poll_req = st_q.req;
    assign btn_q    = st_q.btn;
endmodule

// File: rtl/gpad_rdmux.sv
module gpad_rdmux
    import gpad_pkg::*;
(
    input  acc_e                  acc,
    input  tgt_e                  tgt,
    input  logic                  busy,
    input  word_t [NPLAYERS-1:0]  btn_q,
    output word_t                 rdata
);
    word_t sel_word;

    always_comb begin
        unique case (tgt)
            TGT_STAT: sel_word = {{(DATA_W-1){1'b0}}, busy};
            TGT_P1:   sel_word = btn_q[0];
            TGT_P2:   sel_word = btn_q[1];
            default:  sel_word = '0;
        endcase
    end

    assign rdata = (acc == ACC_RD) ? sel_word : '0;
endmodule

// File: rtl/gpad_poll_regs.sv
module gpad_poll_regs
    import gpad_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              rd_nwr,
    input  logic [1:0]        lane_en,
    input  logic [ADDR_W-1:0] word_ofs,
    output logic [15:0]       rdata,
    output logic              poll_req,
    input  logic              poll_done,
    input  logic [15:0]       p1_btn_in,
    input  logic [15:0]       p2_btn_in
);
    acc_e                 acc;
    tgt_e                 tgt;
    logic                 start_wr;
    logic                 busy;
    word_t [NPLAYERS-1:0] btn_in;
    word_t [NPLAYERS-1:0] btn_q;
    word_t                p1_q;

    gpad_decode #(.ADDR_W(ADDR_W)) dec_i (
        .slot_en  (slot_en),
        .rd_nwr   (rd_nwr),
        .lane_en  (lane_en),
        .word_ofs (word_ofs),
        .acc      (acc),
        .tgt      (tgt)
    );

    assign start_wr  = (acc == ACC_WR) && (tgt == TGT_STAT);
    assign btn_in[0] = p1_btn_in;
    assign btn_in[1] = p2_btn_in;

    gpad_ctrl ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_wr  (start_wr),
        .poll_done (poll_done),
        .btn_in    (btn_in),
        .busy      (busy),
        .poll_req  (poll_req),
        .btn_q     (btn_q)
    );

    assign p1_q = btn_q[0];

    gpad_rdmux mux_i (
        .acc   (acc),
        .tgt   (tgt),
        .busy  (busy),
        .btn_q (btn_q),
        .rdata (rdata)
    );
endmodule

// File: rtl/gpad_poll_chk.sv
module gpad_poll_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_en,
    input logic              rd_nwr,
    input logic [1:0]        lane_en,
    input logic [ADDR_W-1:0] word_ofs,
    input logic [15:0]       rdata,
    input logic              poll_req,
    input logic              poll_done,
    input logic [15:0]       p1_btn_in,
    input logic              busy,
    input logic [15:0]       p1_q
);
    logic start_idle;
    assign start_idle = slot_en && !rd_nwr && (lane_en != 2'b00)
                        && (word_ofs == '0) && !busy;

    a_r2_start_raises: assert property (@(posedge clk) disable iff (!rst_n)
        start_idle |=> (poll_req && busy));

    a_r3_unselected_no_req: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_en && !busy) |=> !poll_req);

    a_r4_busy_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !poll_done) |=> busy);

    a_r4_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && poll_done) |=> (!busy && !poll_req));

    a_r6_req_only_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        poll_req |-> $rose(busy));

    a_r5_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && poll_done) |=> (p1_q == $past(p1_btn_in)));

    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && poll_done) |=> $stable(p1_q));

    a_r9_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_en || rd_nwr == 1'b0 || lane_en == 2'b00) |-> (rdata == 16'h0));

    a_r7_status_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_en && rd_nwr && lane_en != 2'b00 && word_ofs == '0)
            |-> (rdata[15:1] == 15'h0 && rdata[0] == busy));
endmodule

bind gpad_poll_regs gpad_poll_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .slot_en   (slot_en),
    .rd_nwr    (rd_nwr),
    .lane_en   (lane_en),
    .word_ofs  (word_ofs),
    .rdata     (rdata),
    .poll_req  (poll_req),
    .poll_done (poll_done),
    .p1_btn_in (p1_btn_in),
    .busy      (busy),
    .p1_q      (p1_q)
);

// File: tb/gpad_poll_regs_tb_top.sv
module gpad_poll_regs_tb_top;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          slot_en, rd_nwr, poll_done;
    logic [1:0]    lane_en;
    logic [AW-1:0] word_ofs;
    logic [15:0]   p1_btn_in, p2_btn_in;
    logic [15:0]   rdata;
    logic          poll_req;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    logic        m_busy, m_req;
    logic [15:0] m_p1, m_p2;

    always #2 clk = ~clk;

    gpad_poll_regs #(.ADDR_W(AW)) dut_i (
        .clk(clk), .rst_n(rst_n), .slot_en(slot_en), .rd_nwr(rd_nwr),
        .lane_en(lane_en), .word_ofs(word_ofs), .rdata(rdata),
        .poll_req(poll_req), .poll_done(poll_done),
        .p1_btn_in(p1_btn_in), .p2_btn_in(p2_btn_in)
    );

    function automatic logic [15:0] exp_rd(logic sel, logic rd, logic [1:0] ln,
                                           logic [AW-1:0] ofs);
        if (!sel || !rd || ln == 2'b00) return 16'h0;
        case (ofs)
            16'd0:   return {15'h0, m_busy};
            16'd1:   return m_p1;
            16'd2:   return m_p2;
            default: return 16'h0;
        endcase
    endfunction

    function automatic string auto_tag(logic sel, logic rd, logic [1:0] ln,
                                       logic [AW-1:0] ofs);
        if (!sel || !rd || ln == 2'b00) return "R9";
        if (ofs == 0) return "R7";
        return "R8";
    endfunction

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Called at a falling edge: drive, check, advance model across one rising edge.
    task automatic step(logic sel, logic rd, logic [1:0] ln, logic [AW-1:0] ofs,
                        logic dn, logic [15:0] b1, logic [15:0] b2, string tag);
        logic start, fin;
        slot_en = sel; rd_nwr = rd; lane_en = ln; word_ofs = ofs;
        poll_done = dn; p1_btn_in = b1; p2_btn_in = b2;
        #1;
        check((tag == "") ? auto_tag(sel, rd, ln, ofs) : tag, rdata,
              exp_rd(sel, rd, ln, ofs));
        check((tag == "") ? "R2" : tag, {15'h0, poll_req}, {15'h0, m_req});
        start = sel && !rd && ln != 2'b00 && ofs == 0 && !m_busy;
        fin   = dn && m_busy;
        m_req = start;
        if (start) m_busy = 1'b1;
        else if (fin) m_busy = 1'b0;
        if (fin) begin
            m_p1 = b1;
            m_p2 = b2;
        end
        @(negedge clk);
    endtask

    initial begin
        for (int c = 0; c < 150000; c++) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        rst_n = 1'b0;
        slot_en = 0; rd_nwr = 1; lane_en = 2'b11; word_ofs = '0;
        poll_done = 0; p1_btn_in = '0; p2_btn_in = '0;
        m_busy = 0; m_req = 0; m_p1 = '0; m_p2 = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state seen through the bus while still in reset
        slot_en = 1;
        for (int o = 0; o < 3; o++) begin
            word_ofs = AW'(o);
            #1;
            check("R1", rdata, 16'h0);
        end
        check("R1", {15'h0, poll_req}, 16'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R3: stores that must not start a poll
        step(0, 0, 2'b11, 0, 0, 0, 0, "R3");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R3");
        step(1, 0, 2'b11, 1, 0, 0, 0, "R3");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R3");
        step(1, 0, 2'b00, 0, 0, 0, 0, "R3");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R3");
        // R5: done while idle is ignored
        step(1, 1, 2'b11, 1, 1, 16'hAAAA, 16'h5555, "R5");
        step(1, 1, 2'b11, 1, 0, 0, 0, "R5");
        step(1, 1, 2'b11, 2, 0, 0, 0, "R5");
        // R2: start with a single lane and odd data
        step(1, 0, 2'b01, 0, 0, 0, 0, "R2");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R2");
        step(1, 1, 2'b10, 0, 0, 0, 0, "R4");
        // R6: second start while busy
        step(1, 0, 2'b11, 0, 0, 0, 0, "R6");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R6");
        // R4/R5: done completes the poll
        step(1, 1, 2'b11, 2, 1, 16'h1234, 16'h5678, "R4");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R4");
        step(1, 1, 2'b11, 1, 0, 16'hFFFF, 16'hFFFF, "R5");
        step(1, 1, 2'b11, 2, 0, 0, 0, "R5");
        // R6: start store in the same cycle as done
        step(1, 0, 2'b11, 0, 0, 0, 0, "R2");
        step(1, 0, 2'b11, 0, 1, 16'h0F0F, 16'hF0F0, "R6");
        step(1, 1, 2'b11, 0, 0, 0, 0, "R6");
        step(1, 1, 2'b11, 1, 0, 0, 0, "R5");
        // R8/R9: unused offset and non-read cycles
        step(1, 1, 2'b11, 3, 0, 0, 0, "R8");
        step(1, 1, 2'b11, 16'h8001, 0, 0, 0, "R8");
        step(0, 1, 2'b11, 1, 0, 0, 0, "R9");
        step(1, 0, 2'b11, 2, 0, 0, 0, "R9");
        step(1, 1, 2'b00, 1, 0, 0, 0, "R9");

        // Constrained random traffic with an engine-like done source
        for (int i = 0; i < 4000; i++) begin
            logic          s, r, d;
            logic [1:0]    l;
            logic [AW-1:0] o;
            s = ($urandom % 10) < 7;
            r = ($urandom % 2) == 0;
            l = 2'($urandom % 4);
            o = (($urandom % 5) == 0) ? AW'($urandom) : AW'($urandom % 4);
            d = ($urandom % 8) == 0;
            step(s, r, l, o, d, 16'($urandom), 16'($urandom), "");
        end

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule